// File: doc/BRIEF.md
# MII Management Master

This block issues single read and write transactions on the two-wire PHY management bus (MDC clock, bidirectional MDIO data). Host software sees three 16-bit registers behind a simple write strobe and a combinational read port: a command word, a write-data word and a read-data word. To write a PHY register, software first loads the write-data word and then writes the command word with the write bit set. To read, it writes the command word with the read bit set. Either way it then polls the command word until that operation bit returns to zero.

While a command is in flight, the controller generates MDC from the system clock, shifts out the complete management frame and, for reads, releases MDIO for the turnaround and the data phase. It captures the sixteen returned bits and stores them in the read-data word. When the last bit time ends, it clears the operation bit in the same clock edge that loads the read data. An absent PHY leaves the line pulled high, so the read returns all ones.

Top module: `mdio_master`

## Requirements
- R1: Command word layout: bit 14 requests a write, bit 13 requests a read, bits 12:8 hold the 5-bit PHY address and bits 4:0 the 5-bit register number. Bits 15 and 7:5 are discarded and read back as 0. Host select codes are 0 command, 1 write data, 2 read data, 3 reads zero.
- R2: Each frame is 64 MDC periods long and consists of 32 ones, start bits 0 then 1, opcode 1,0 for a read or 0,1 for a write, the PHY address MSB first, then the register number MSB first.
- R3: On a write, the controller drives MDIO for all 64 bits. The turnaround is 1 then 0, followed by the write-data word MSB first, as it stood when the command was accepted.
- R4: On a read, mdio_oe is low for bit times 46 to 63 (turnaround and data). The bits sampled at the 16 data rising edges of MDC are stored MSB first in the read-data word.
- R5: After an accepted command, its operation bit reads 1 until the frame ends and then reads 0. The address and register fields remain. Read data is valid once the bit is 0.
- R6: A read with nothing driving MDIO (pulled high) returns 0xFFFF.
- R7: MDC has a period of 2*HALF_DIV system clocks during a frame and stays low when idle. mdio_o changes only while MDC is low.
- R8: A command write while an operation bit is set is ignored: the command word is unchanged and the running frame completes as started.
- R9: A command with both operation bits set runs as a read and reads back with only bit 13 set.
- R10: After reset, all three registers read 0, MDC is low and mdio_oe is low.
- R11: A command with neither operation bit set stores its fields but starts no frame (no MDC edges).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 2 | Register select (0 command, 1 write data, 2 read data) |
| host_wdata | input | 16 | Register write value |
| host_rdata | output | 16 | Selected register value |
| mdc | output | 1 | Management clock to PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high = drive) |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
A wrong bit counter or shift register shows up within one frame. A fault in the header shifts the PHY address or register bits as seen by the PHY model at MDC rising edges. A fault in the data phase corrupts the read-data word, or leaves mdio_oe high when the PHY should be driving. A stuck or early busy clear appears on the next poll of the command word, so it is visible well within one frame time. Divider faults change the measured MDC period from the first bit time, and the bench also flags any MDIO change during MDC high.

// File: rtl/mdio_pkg.sv
// Shared constants, register select codes and the frame builder for the
// MII management master. Assumes the 64-bit clause-22 frame with preamble.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = 46;   // first turnaround bit time
    localparam int DATA_IDX   = 48;   // first data bit time
    localparam int FLD_W      = 5;
    localparam int WORD_W     = 16;
    localparam int WR_BIT     = 14;
    localparam int RD_BIT     = 13;
    localparam int PHY_LSB    = 8;

    typedef enum logic [1:0] {
        SEL_CMD   = 2'd0,
        SEL_WDATA = 2'd1,
        SEL_RDATA = 2'd2,
        SEL_NONE  = 2'd3
    } host_sel_e;

    // Assemble the full frame, first bit at the MSB.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              rd,
        input logic [FLD_W-1:0]  phy,
        input logic [FLD_W-1:0]  regn,
        input logic [WORD_W-1:0] data
    );
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [WORD_W-1:0] payload;
        op      = rd ? 2'b10 : 2'b01;
        ta      = rd ? 2'b11 : 2'b10;
        payload = rd ? {WORD_W{1'b1}} : data;
        return {32'hFFFF_FFFF, 2'b01, op, phy, regn, ta, payload};
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
// MDC generator: divides clk by 2*HALF_DIV while run is high and flags the
// clk edges at which MDC rises and falls. Assumes run drops at a fall tick,
// so MDC is already low when it stops.
module mdio_clk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    logic tick;

    generate
        if (HALF_DIV == 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            localparam int CW = $clog2(HALF_DIV);
            logic [CW-1:0] cnt;
            // Count clk cycles within one MDC half period.
            always_ff @(posedge clk) begin
                if (!rst_n || !run)
                    cnt <= '0;
                else if (cnt == CW'(HALF_DIV - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
            assign tick = run && (cnt == CW'(HALF_DIV - 1));
        end
    endgenerate

    // Toggle MDC at each half-period boundary, hold it low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            mdc <= 1'b0;
        else if (tick)
            mdc <= ~mdc;
    end

    assign rise_tick = tick && !mdc;
    assign fall_tick = tick &&  mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame shifter: loads the whole frame on start, advances one bit per MDC
// falling edge, releases MDIO from the read turnaround on and captures read
// data on MDC rising edges. Assumes start is only given while idle.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_read,
    input  logic [FLD_W-1:0]  phy_addr,
    input  logic [FLD_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              is_read,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [WORD_W-1:0] rd_word,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic [FRAME_BITS-1:0] shreg;
    logic [FRAME_BITS-1:0] frame;
    logic [CNT_W-1:0]      nxt;
    logic                  last;

    assign frame = build_frame(start_read, phy_addr, reg_addr, wr_word);
    assign nxt   = bit_cnt + 1'b1;
    assign last  = (bit_cnt == CNT_W'(FRAME_BITS - 1));
    assign done  = busy && fall_tick && last;

    // Load, advance and finish the frame; drive MDIO only where allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            is_read <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            is_read <= start_read;
            bit_cnt <= '0;
            shreg   <= frame;
            mdio_o  <= frame[FRAME_BITS-1];
            mdio_oe <= 1'b1;
        end else if (busy && fall_tick) begin
            if (last) begin
                busy    <= 1'b0;
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b0;
            end else begin
                bit_cnt <= nxt;
                shreg   <= shreg << 1;
                mdio_o  <= shreg[FRAME_BITS-2];
                mdio_oe <= !(is_read && (nxt >= CNT_W'(TA_IDX)));
            end
        end
    end

    // Shift in returned data bits at MDC rising edges of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_word <= '0;
        else if (busy && rise_tick && is_read && (bit_cnt >= CNT_W'(DATA_IDX)))
            rd_word <= {rd_word[WORD_W-2:0], mdio_i};
    end
endmodule

// File: rtl/mdio_host_regs.sv
// Host-visible registers: command word with self-clearing operation bits,
// write-data and read-data words. Assumes eng_done pulses for one clk.
module mdio_host_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              eng_done,
    input  logic              eng_is_read,
    input  logic [WORD_W-1:0] eng_rd_word,
    output logic [WORD_W-1:0] cmd_q,
    output logic [WORD_W-1:0] wdata_q,
    output logic [WORD_W-1:0] rdata_q,
    output logic              op_busy,
    output logic              start,
    output logic              start_read,
    output logic [FLD_W-1:0]  start_phy,
    output logic [FLD_W-1:0]  start_reg
);
    logic              cmd_acc;
    logic              want_rd;
    logic              want_wr;
    logic [WORD_W-1:0] cmd_next;

    assign op_busy    = cmd_q[WR_BIT] | cmd_q[RD_BIT];
    assign cmd_acc    = host_we && (host_sel == SEL_CMD) && !op_busy;
    assign want_rd    = host_wdata[RD_BIT];
    assign want_wr    = host_wdata[WR_BIT] && !host_wdata[RD_BIT];
    assign start_phy  = host_wdata[PHY_LSB +: FLD_W];
    assign start_reg  = host_wdata[FLD_W-1:0];
    assign cmd_next   = {1'b0, want_wr, want_rd, start_phy, 3'b000, start_reg};
    assign start      = cmd_acc && (want_rd || want_wr);
    assign start_read = want_rd;

    // Accept commands while idle; clear the operation bit when the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (cmd_acc)
            cmd_q <= cmd_next;
        else if (eng_done) begin
            cmd_q[WR_BIT] <= 1'b0;
            cmd_q[RD_BIT] <= 1'b0;
        end
    end

    // Hold the data word for the next write frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdata_q <= '0;
        else if (host_we && (host_sel == SEL_WDATA))
            wdata_q <= host_wdata;
    end

    // Publish captured read data at the end of a read frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (eng_done && eng_is_read)
            rdata_q <= eng_rd_word;
    end
endmodule

// File: rtl/mdio_master.sv
// MII management master top: host registers, MDC divider and frame engine.
// Assumes an external pull-up on MDIO and a tri-state pad built from
// mdio_o/mdio_oe, with the pad value returned on mdio_i.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [WORD_W-1:0] cmd_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] eng_rd_word;
    logic              op_busy;
    logic              start;
    logic              start_read;
    logic [FLD_W-1:0]  start_phy;
    logic [FLD_W-1:0]  start_reg;
    logic              eng_busy;
    logic              eng_done;
    logic              eng_is_read;
    logic [CNT_W-1:0]  eng_bit_cnt;
    logic              rise_tick;
    logic              fall_tick;

    mdio_host_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (host_we),
        .host_sel    (host_sel),
        .host_wdata  (host_wdata),
        .eng_done    (eng_done),
        .eng_is_read (eng_is_read),
        .eng_rd_word (eng_rd_word),
        .cmd_q       (cmd_q),
        .wdata_q     (wdata_q),
        .rdata_q     (rdata_q),
        .op_busy     (op_busy),
        .start       (start),
        .start_read  (start_read),
        .start_phy   (start_phy),
        .start_reg   (start_reg)
    );

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_read (start_read),
        .phy_addr   (start_phy),
        .reg_addr   (start_reg),
        .wr_word    (wdata_q),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_i     (mdio_i),
        .busy       (eng_busy),
        .done       (eng_done),
        .is_read    (eng_is_read),
        .bit_cnt    (eng_bit_cnt),
        .rd_word    (eng_rd_word),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    // Host read multiplexer.
    always_comb begin
        case (host_sel)
            SEL_CMD:   host_rdata = cmd_q;
            SEL_WDATA: host_rdata = wdata_q;
            SEL_RDATA: host_rdata = rdata_q;
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_master_chk.sv
// Property checker for mdio_master, attached by bind below.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        op_busy,
    input logic [15:0] cmd_q,
    input logic        eng_busy,
    input logic        eng_done,
    input logic        eng_is_read,
    input logic [5:0]  eng_bit_cnt
);
    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !op_busy |-> !mdc); // R7
    AST_MDIO_STABLE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o)); // R7
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && eng_is_read && eng_bit_cnt >= 6'd46) |-> !mdio_oe); // R4
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && !eng_done) |=> op_busy); // R5
    AST_CMD_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_busy) && op_busy) |-> $stable(cmd_q)); // R8
    AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_q[14:13]) <= 1); // R9
    AST_ENGINE_TRACKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> op_busy); // R5
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .op_busy     (op_busy),
    .cmd_q       (cmd_q),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .eng_is_read (eng_is_read),
    .eng_bit_cnt (eng_bit_cnt)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int HALF = 4;
    localparam int NVEC = 6;
    // {op[1:0] (bit14,bit13), phy, reg, wdata, phy data, phy present, junk}
    localparam logic [45:0] VEC [NVEC] = '{
        {2'b10, 5'd1,  5'd0,  16'h3100, 16'h0000, 1'b1, 1'b0},
        {2'b01, 5'd1,  5'd2,  16'h0000, 16'h0243, 1'b1, 1'b1},
        {2'b01, 5'd31, 5'd31, 16'h0000, 16'hA55A, 1'b1, 1'b0},
        {2'b01, 5'd3,  5'd1,  16'h0000, 16'h1357, 1'b0, 1'b0},
        {2'b10, 5'd30, 5'd17, 16'h8001, 16'h0000, 1'b1, 1'b1},
        {2'b11, 5'd5,  5'd4,  16'h0000, 16'h1234, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // PHY model state
    int          rise_cnt = 0;
    logic [63:0] cap = '0;
    logic [63:0] oe_cap = '0;
    logic        phy_present = 1'b1;
    logic [15:0] phy_data = 16'h0;
    logic        drv_en = 1'b0;
    logic        drv_val = 1'b1;
    int          bad_period = 0;
    int          bad_change = 0;
    realtime     last_rise = 0;

    always #10 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (drv_en ? drv_val : 1'b1);

    mdio_master #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge mdc) begin
        if (rise_cnt > 0 && rise_cnt < 64 && ($realtime - last_rise) != real'(2 * HALF * 20))
            bad_period++;
        last_rise = $realtime;
        if (rise_cnt < 64) begin
            cap[63 - rise_cnt]    = mdio_i;
            oe_cap[63 - rise_cnt] = mdio_oe;
        end
        rise_cnt++;
    end

    always @(negedge mdc) begin
        if (phy_present && rise_cnt == 47) begin
            drv_en = 1'b1; drv_val = 1'b0;
        end else if (phy_present && rise_cnt >= 48 && rise_cnt <= 63) begin
            drv_en = 1'b1; drv_val = phy_data[63 - rise_cnt];
        end else begin
            drv_en = 1'b0; drv_val = 1'b1;
        end
    end

    logic prev_mdc = 1'b0, prev_o = 1'b1;
    always @(negedge clk) begin
        if (mdc && prev_mdc && mdio_o != prev_o) bad_change++;
        prev_mdc = mdc;
        prev_o   = mdio_o;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] sel, output logic [15:0] d);
        host_sel = sel;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            host_read(2'd0, v);
            if (v[14:13] == 2'b00) return;
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wd)};
    endfunction

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (5) @(negedge clk);
        // R10: reset state
        host_read(2'd0, v); check("R10 cmd", v, 0);
        host_read(2'd1, v); check("R10 wdata", v, 0);
        host_read(2'd2, v); check("R10 rdata", v, 0);
        check("R10 mdc/oe", {mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        host_read(2'd3, v); check("R1 unused select", v, 0);

        // Table-driven transactions
        for (int k = 0; k < NVEC; k++) begin
            logic [1:0]  op;
            logic [4:0]  phy, rg;
            logic [15:0] wd, pd, cmd, expcmd;
            logic        pres, junk, rd;
            {op, phy, rg, wd, pd, pres, junk} = VEC[k];
            rd  = op[0];
            cmd = {junk, op[1], op[0], phy, (junk ? 3'b111 : 3'b000), rg};
            expcmd = {1'b0, op[1] & ~op[0], op[0], phy, 3'b000, rg};
            phy_present = pres;
            phy_data    = pd;
            if (!rd) host_write(2'd1, wd);
            rise_cnt = 0;
            host_write(2'd0, cmd);
            host_read(2'd0, v);
            check(rd && op[1] ? "R9 both bits read" : "R1 masked command busy", v, expcmd);
            wait_idle();
            host_read(2'd0, v);
            check("R5 op bit cleared, fields kept", v, {expcmd[15], 2'b00, expcmd[12:0]});
            check("R2 frame length", rise_cnt, 64);
            check("R2 frame header", cap[63:18], exp_frame(rd, phy, rg, wd) >> 18);
            if (rd) begin
                check("R4 released for TA and data", oe_cap[17:0], 0);
                host_read(2'd2, v);
                check(pres ? "R4 read data" : "R6 absent PHY", v, pres ? pd : 16'hFFFF);
            end else begin
                check("R3 TA and write data", cap[17:0], exp_frame(0, phy, rg, wd) & 64'h3FFFF);
                check("R3 driven whole frame", oe_cap, 64'hFFFF_FFFF_FFFF_FFFF);
            end
        end
        check("R7 mdc period", bad_period, 0);
        check("R7 mdio stable while mdc high", bad_change, 0);
        check("R7 mdc low when idle", mdc, 0);

        // R8: command while busy is ignored
        phy_present = 1'b1; phy_data = 16'h0F0F;
        rise_cnt = 0;
        host_write(2'd0, 16'h2203);
        repeat (100) @(negedge clk);
        host_write(2'd0, 16'h4707);
        host_read(2'd0, v);
        check("R8 cmd unchanged while busy", v, 16'h2203);
        wait_idle();
        check("R8 frame as started", cap[63:18], exp_frame(1, 5'd2, 5'd3, 0) >> 18);
        host_read(2'd2, v);
        check("R8 read data of first command", v, 16'h0F0F);

        // R11: no operation bit, no frame
        rise_cnt = 0;
        host_write(2'd0, 16'h0A15);
        repeat (200) @(negedge clk);
        check("R11 no mdc edges", rise_cnt, 0);
        host_read(2'd0, v);
        check("R11 fields stored", v, 16'h0A15);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule